// File: doc/BRIEF.md
# Programmable External Memory Bus Controller

This block bridges an internal request port to an asynchronous parallel bus carrying nine word-address lines, a 16-bit data path, output-enable, write-enable, an address-valid strobe and six active-low chip selects. An accepted byte address is matched against six fixed windows. A hit runs one bus cycle whose shape comes from that chip select's own timing inputs. A miss answers at once with an error and leaves the bus untouched.

The sequence of one access is a fixed chain of optional phases. Turnaround comes first, then first-access latency. Fast-mode chip selects add an address-valid strobe and a spacing gap. The strobe phase follows, and writes end with a hold phase. A phase whose programmed length works out to zero is skipped. Turnaround is inserted only after a read, and only when the next access moves to another chip select or is a write to the same one.

The request side uses valid/ready. `req_ready` is high only while the controller is idle, and one request is outstanding at a time. A requester holds `req_valid` and its fields stable until it sees `req_ready`. The response is a one-cycle strobe with no back-pressure, so the requester must be able to take it at any cycle.

Top module: `extbus_ctrl`

## Requirements
- R1: Byte address windows map to chip-select index and `bus_cs_n` bit: 0x1A800000–0x1AFFFFFF→0, 0x1B000000–0x1B7FFFFF→1, 0x1B800000–0x1BFFFFFF→2, 0x1C000000–0x1C7FFFFF→5, 0x1C800000–0x1CFFFFFF→4, 0x1D000000–0x24FFFFFF→3. At most one bit of `bus_cs_n` is low at any time, and `bus_addr` carries byte address bits 9:1.
- R2: An address outside every window gives `rsp_valid` with `rsp_err`=1 one cycle after acceptance. No chip select, OE or WE goes low, and the access does not change the turnaround or page history.
- R3: A read holds `bus_oe_n` low for read-wait+1 cycles (4-bit field per chip select). `rsp_rdata` returns `bus_din` as sampled on the last of those cycles. OE and WE are never low together.
- R4: A write holds `bus_we_n` low for write-wait+1 cycles with `bus_dout` equal to the request data and `bus_doe`=1. `bus_doe` is never high while OE is low.
- R5: After WE rises on a write, the chip select stays low with `bus_doe`=1 for write-hold+1 cycles (4-bit field).
- R6: When the previous completed access was a read and the new access targets a different chip select or is a write, the controller idles with all chip selects high for max(recovery,1) cycles (4-bit field) before asserting a chip select. Otherwise it inserts no such idle cycles.
- R7: When the chip select or byte address bits 31:10 differ from the previous completed access, or no access has completed since reset, the chip select is held low with no strobe for read-delta or write-delta cycles (8-bit fields, 0 to 255) before the strobe phase.
- R8: A chip select with its fast bit set drives `bus_adv_n` low for exactly one cycle with the chip select low. A spacing gap then follows before the strobe: max(adv-to-OE (2-bit), read-hold (4-bit)) cycles for reads, and adv-to-OE cycles for writes. A slow chip select never pulses ADV.
- R9: With the address-hold bit set on a fast chip select, the gap after ADV grows by one cycle, during which the address stays driven.
- R10: `req_ready` is low from the cycle after acceptance until the cycle after the response strobe. `rsp_valid` is a single-cycle pulse per accepted request. The response comes one cycle after the last chip-select-low cycle.
- R11: After reset `req_ready`=1, `rsp_valid`=0, all chip selects, OE, WE and ADV are high, and `bus_doe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Address matched no window |
| rsp_rdata | output | 16 | Read data |
| cfg_rd_wait | input | 24 | Read wait field, 4 bits per chip select |
| cfg_wr_wait | input | 24 | Write wait field, 4 bits per chip select |
| cfg_recov | input | 24 | Turnaround field, 4 bits per chip select |
| cfg_wr_hold | input | 24 | Write hold field, 4 bits per chip select |
| cfg_rd_delta | input | 48 | Read first-access latency, 8 bits per chip select |
| cfg_wr_delta | input | 48 | Write first-access latency, 8 bits per chip select |
| cfg_fast | input | 6 | Fast-mode enable per chip select |
| cfg_adv_oe | input | 12 | ADV-to-strobe spacing, 2 bits per chip select |
| cfg_rd_hold | input | 24 | Fast read first segment, 4 bits per chip select |
| cfg_addr_hold | input | 6 | Extra address cycle after ADV per chip select |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_addr | output | 9 | Word address |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_adv_n | output | 1 | Active-low address valid |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Tri-state enable for bus_dout |
| bus_din | input | 16 | Read data from the bus |

## Verification
A request taken at a clock edge has its first phase visible one cycle later. Each phase's cycles then follow back to back, and the response appears exactly one cycle after the last chip-select-low cycle. Error responses appear one cycle after acceptance. The bench drives and samples on the falling edge and counts, from the accepting edge onward, the cycles spent in each bus state. It compares each count, and the total latency, with the sum predicted from the per-chip-select fields and its own record of the previous access. It also confirms that `req_ready` is back high in the cycle after the response.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  localparam int NUM_CS = 6;
  localparam int PH_N   = 8;

  // Phase order is the order in which a bus access walks through them.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RECOV = 3'd1,
    PH_DELTA = 3'd2,
    PH_ADV   = 3'd3,
    PH_GAP   = 3'd4,
    PH_ACC   = 3'd5,
    PH_HOLD  = 3'd6,
    PH_RESP  = 3'd7
  } phase_e;

  // Chip-select windows, indexed by chip-select number.
  localparam logic [31:0] WIN_FIRST [NUM_CS] = '{
    32'h1A80_0000, 32'h1B00_0000, 32'h1B80_0000,
    32'h1D00_0000, 32'h1C80_0000, 32'h1C00_0000
  };
  localparam logic [31:0] WIN_LAST [NUM_CS] = '{
    32'h1AFF_FFFF, 32'h1B7F_FFFF, 32'h1BFF_FFFF,
    32'h24FF_FFFF, 32'h1CFF_FFFF, 32'h1C7F_FFFF
  };

endpackage

// File: rtl/extbus_decode.sv
module extbus_decode
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  logic [NUM_CS-1:0] win_hit;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign win_hit[g] = (addr >= WIN_FIRST[g]) && (addr <= WIN_LAST[g]);
  end

  always_comb begin
    hit = |win_hit;
    idx = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (win_hit[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/extbus_timing.sv
module extbus_timing
  import extbus_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int WAIT_W  = 4,
  parameter int DELTA_W = 8,
  parameter int SPACE_W = 2,
  parameter int PAGE_W  = 22,
  parameter int CNT_W   = 8
) (
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_rd_wait,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_wr_wait,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_recov,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_wr_hold,
  input  logic [NUM_CS*DELTA_W-1:0] cfg_rd_delta,
  input  logic [NUM_CS*DELTA_W-1:0] cfg_wr_delta,
  input  logic [NUM_CS-1:0]         cfg_fast,
  input  logic [NUM_CS*SPACE_W-1:0] cfg_adv_oe,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_rd_hold,
  input  logic [NUM_CS-1:0]         cfg_addr_hold,
  input  logic [IDX_W-1:0]          sel_idx,
  input  logic                      sel_wr,
  input  logic [PAGE_W-1:0]         sel_page,
  input  logic                      hist_valid,
  input  logic                      hist_read,
  input  logic [IDX_W-1:0]          hist_idx,
  input  logic [PAGE_W-1:0]         hist_page,
  output logic [PH_N-1:0]           ph_en,
  output logic [PH_N-1:0][CNT_W-1:0] ph_lenm1
);

  logic [WAIT_W-1:0]  rd_wait, wr_wait, recov, wr_hold, rd_hold;
  logic [DELTA_W-1:0] rd_delta, wr_delta, delta;
  logic [SPACE_W-1:0] adv_oe;
  logic               fast, addr_hold;
  logic               need_recov, new_page;
  logic [CNT_W-1:0]   gap_base, gap;

  always_comb begin
    rd_wait   = cfg_rd_wait [int'(sel_idx)*WAIT_W  +: WAIT_W];
    wr_wait   = cfg_wr_wait [int'(sel_idx)*WAIT_W  +: WAIT_W];
    recov     = cfg_recov   [int'(sel_idx)*WAIT_W  +: WAIT_W];
    wr_hold   = cfg_wr_hold [int'(sel_idx)*WAIT_W  +: WAIT_W];
    rd_hold   = cfg_rd_hold [int'(sel_idx)*WAIT_W  +: WAIT_W];
    rd_delta  = cfg_rd_delta[int'(sel_idx)*DELTA_W +: DELTA_W];
    wr_delta  = cfg_wr_delta[int'(sel_idx)*DELTA_W +: DELTA_W];
    adv_oe    = cfg_adv_oe  [int'(sel_idx)*SPACE_W +: SPACE_W];
    fast      = cfg_fast[sel_idx];
    addr_hold = cfg_addr_hold[sel_idx];
  end

  always_comb begin
    need_recov = hist_valid && hist_read && ((hist_idx != sel_idx) || sel_wr);
    new_page   = !hist_valid || (hist_idx != sel_idx) || (hist_page != sel_page);
    delta      = sel_wr ? wr_delta : rd_delta;

    if (sel_wr || (CNT_W'(adv_oe) >= CNT_W'(rd_hold))) gap_base = CNT_W'(adv_oe);
    else                                               gap_base = CNT_W'(rd_hold);
    gap = gap_base + CNT_W'(addr_hold);

    ph_en    = '0;
    ph_lenm1 = '0;

    ph_en[PH_RECOV]    = need_recov;
    ph_lenm1[PH_RECOV] = (recov == '0) ? '0 : CNT_W'(recov) - CNT_W'(1);

    ph_en[PH_DELTA]    = new_page && (delta != '0);
    ph_lenm1[PH_DELTA] = CNT_W'(delta) - CNT_W'(1);

    ph_en[PH_ADV]      = fast;

    ph_en[PH_GAP]      = fast && (gap != '0);
    ph_lenm1[PH_GAP]   = gap - CNT_W'(1);

    ph_en[PH_ACC]      = 1'b1;
    ph_lenm1[PH_ACC]   = CNT_W'(sel_wr ? wr_wait : rd_wait);

    ph_en[PH_HOLD]     = sel_wr;
    ph_lenm1[PH_HOLD]  = CNT_W'(wr_hold);

    ph_en[PH_RESP]     = 1'b1;
  end

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int BUS_AW = 9,
  parameter int PAGE_W = 22,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-2:0]          req_waddr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic                       dec_hit,
  input  logic [IDX_W-1:0]           dec_idx,
  input  logic [PH_N-1:0]            ph_en,
  input  logic [PH_N-1:0][CNT_W-1:0] ph_lenm1,
  input  logic [DATA_W-1:0]          bus_din,
  output phase_e                     phase,
  output logic [IDX_W-1:0]           cur_idx,
  output logic                       cur_wr,
  output logic [ADDR_W-2:0]          cur_waddr,
  output logic [DATA_W-1:0]          cur_wdata,
  output logic                       rsp_err,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       hist_valid,
  output logic                       hist_read,
  output logic [IDX_W-1:0]           hist_idx,
  output logic [PAGE_W-1:0]          hist_page
);

  logic [CNT_W-1:0] cnt;
  phase_e           nxt;

  // First enabled phase after the current one; the response phase is always enabled.
  always_comb begin
    nxt = PH_RESP;
    for (int q = PH_N - 1; q >= 0; q--) begin
      if ((q > int'(phase)) && ph_en[q]) nxt = phase_e'(q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      cur_idx    <= '0;
      cur_wr     <= 1'b0;
      cur_waddr  <= '0;
      cur_wdata  <= '0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      hist_valid <= 1'b0;
      hist_read  <= 1'b0;
      hist_idx   <= '0;
      hist_page  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            cur_idx   <= dec_idx;
            cur_wr    <= req_write;
            cur_waddr <= req_waddr;
            cur_wdata <= req_wdata;
            if (!dec_hit) begin
              rsp_err <= 1'b1;
              phase   <= PH_RESP;
            end else begin
              rsp_err <= 1'b0;
              phase   <= nxt;
              cnt     <= ph_lenm1[nxt];
            end
          end
        end
        PH_RESP: begin
          phase <= PH_IDLE;
          if (!rsp_err) begin
            hist_valid <= 1'b1;
            hist_read  <= !cur_wr;
            hist_idx   <= cur_idx;
            hist_page  <= cur_waddr[ADDR_W-2:BUS_AW];
          end
        end
        default: begin
          if ((phase == PH_ACC) && !cur_wr && (cnt == '0)) rsp_rdata <= bus_din;
          if (cnt == '0) begin
            phase <= nxt;
            cnt   <= ph_lenm1[nxt];
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 16,
  parameter int BUS_AW  = 9,
  parameter int WAIT_W  = 4,
  parameter int DELTA_W = 8,
  parameter int SPACE_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  output logic                      rsp_err,
  output logic [DATA_W-1:0]         rsp_rdata,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_rd_wait,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_wr_wait,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_recov,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_wr_hold,
  input  logic [NUM_CS*DELTA_W-1:0] cfg_rd_delta,
  input  logic [NUM_CS*DELTA_W-1:0] cfg_wr_delta,
  input  logic [NUM_CS-1:0]         cfg_fast,
  input  logic [NUM_CS*SPACE_W-1:0] cfg_adv_oe,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_rd_hold,
  input  logic [NUM_CS-1:0]         cfg_addr_hold,
  output logic [NUM_CS-1:0]         bus_cs_n,
  output logic [BUS_AW-1:0]         bus_addr,
  output logic                      bus_oe_n,
  output logic                      bus_we_n,
  output logic                      bus_adv_n,
  output logic [DATA_W-1:0]         bus_dout,
  output logic                      bus_doe,
  input  logic [DATA_W-1:0]         bus_din
);

  localparam int IDX_W  = $clog2(NUM_CS);
  localparam int PAGE_W = ADDR_W - BUS_AW - 1;
  localparam int CNT_W  = (DELTA_W > WAIT_W + 1) ? DELTA_W : WAIT_W + 1;

  logic                       dec_hit;
  logic [IDX_W-1:0]           dec_idx;
  phase_e                     phase;
  logic [IDX_W-1:0]           cur_idx;
  logic                       cur_wr;
  logic [ADDR_W-2:0]          cur_waddr;
  logic [DATA_W-1:0]          cur_wdata;
  logic                       hist_valid, hist_read;
  logic [IDX_W-1:0]           hist_idx;
  logic [PAGE_W-1:0]          hist_page;
  logic [PH_N-1:0]            ph_en;
  logic [PH_N-1:0][CNT_W-1:0] ph_lenm1;
  logic                       idle;
  logic [IDX_W-1:0]           sel_idx;
  logic                       sel_wr;
  logic [PAGE_W-1:0]          sel_page;
  logic                       cs_active;

  extbus_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr (req_addr),
    .hit  (dec_hit),
    .idx  (dec_idx)
  );

  // While idle the timing is computed for the incoming request, later for the latched one.
  assign idle     = (phase == PH_IDLE);
  assign sel_idx  = idle ? dec_idx   : cur_idx;
  assign sel_wr   = idle ? req_write : cur_wr;
  assign sel_page = idle ? req_addr[ADDR_W-1:BUS_AW+1] : cur_waddr[ADDR_W-2:BUS_AW];

  extbus_timing #(
    .IDX_W(IDX_W), .WAIT_W(WAIT_W), .DELTA_W(DELTA_W),
    .SPACE_W(SPACE_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)
  ) u_timing (
    .cfg_rd_wait   (cfg_rd_wait),
    .cfg_wr_wait   (cfg_wr_wait),
    .cfg_recov     (cfg_recov),
    .cfg_wr_hold   (cfg_wr_hold),
    .cfg_rd_delta  (cfg_rd_delta),
    .cfg_wr_delta  (cfg_wr_delta),
    .cfg_fast      (cfg_fast),
    .cfg_adv_oe    (cfg_adv_oe),
    .cfg_rd_hold   (cfg_rd_hold),
    .cfg_addr_hold (cfg_addr_hold),
    .sel_idx       (sel_idx),
    .sel_wr        (sel_wr),
    .sel_page      (sel_page),
    .hist_valid    (hist_valid),
    .hist_read     (hist_read),
    .hist_idx      (hist_idx),
    .hist_page     (hist_page),
    .ph_en         (ph_en),
    .ph_lenm1      (ph_lenm1)
  );

  extbus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .BUS_AW(BUS_AW), .PAGE_W(PAGE_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_waddr  (req_addr[ADDR_W-1:1]),
    .req_wdata  (req_wdata),
    .dec_hit    (dec_hit),
    .dec_idx    (dec_idx),
    .ph_en      (ph_en),
    .ph_lenm1   (ph_lenm1),
    .bus_din    (bus_din),
    .phase      (phase),
    .cur_idx    (cur_idx),
    .cur_wr     (cur_wr),
    .cur_waddr  (cur_waddr),
    .cur_wdata  (cur_wdata),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .hist_valid (hist_valid),
    .hist_read  (hist_read),
    .hist_idx   (hist_idx),
    .hist_page  (hist_page)
  );

  always_comb begin
    cs_active = (phase == PH_DELTA) || (phase == PH_ADV) || (phase == PH_GAP) ||
                (phase == PH_ACC)   || (phase == PH_HOLD);
    bus_cs_n  = cs_active ? ~(NUM_CS'(1) << cur_idx) : '1;
    bus_addr  = cur_waddr[BUS_AW-1:0];
    bus_adv_n = !(phase == PH_ADV);
    bus_oe_n  = !((phase == PH_ACC) && !cur_wr);
    bus_we_n  = !((phase == PH_ACC) && cur_wr);
    bus_doe   = cur_wr && ((phase == PH_ACC) || (phase == PH_HOLD));
    bus_dout  = cur_wdata;
    req_ready = idle;
    rsp_valid = (phase == PH_RESP);
  end

endmodule

// File: rtl/extbus_ctrl_sva.sv
module extbus_ctrl_sva
  import extbus_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_oe_n,
  input logic              bus_we_n,
  input logic              bus_adv_n,
  input logic              bus_doe
);

  a_r1_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> ((&bus_cs_n) && $past(req_ready)));

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  a_r3_oe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !(&bus_cs_n));

  a_r4_doe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_oe_n && !(&bus_cs_n)));

  a_r5_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> (bus_doe && !(&bus_cs_n)));

  a_r8_adv_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |-> (!(&bus_cs_n) && bus_oe_n && bus_we_n));

  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind extbus_ctrl extbus_ctrl_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .bus_cs_n  (bus_cs_n),
  .bus_oe_n  (bus_oe_n),
  .bus_we_n  (bus_we_n),
  .bus_adv_n (bus_adv_n),
  .bus_doe   (bus_doe)
);

// File: tb/extbus_ctrl_test.sv
`timescale 1ns/1ps
module extbus_ctrl_test;
  import extbus_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, rsp_valid, rsp_err;
  logic [31:0] req_addr;
  logic [15:0] req_wdata, rsp_rdata, bus_dout, bus_din;
  logic [23:0] rd_wait, wr_wait, recov, wr_hold, rd_hold;
  logic [47:0] rd_delta, wr_delta;
  logic [5:0]  fast, addr_hold, bus_cs_n;
  logic [11:0] adv_oe;
  logic [8:0]  bus_addr;
  logic        bus_oe_n, bus_we_n, bus_adv_n, bus_doe;

  extbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_rd_wait(rd_wait), .cfg_wr_wait(wr_wait), .cfg_recov(recov),
    .cfg_wr_hold(wr_hold), .cfg_rd_delta(rd_delta), .cfg_wr_delta(wr_delta),
    .cfg_fast(fast), .cfg_adv_oe(adv_oe), .cfg_rd_hold(rd_hold),
    .cfg_addr_hold(addr_hold), .bus_cs_n(bus_cs_n), .bus_addr(bus_addr),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_adv_n(bus_adv_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  int checks = 0, failures = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [15:0] wd;
    logic [15:0] din;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h1A80_0010, 16'h0000, 16'hA001},
    '{1'b0, 32'h1A80_0020, 16'h0000, 16'hA002},
    '{1'b1, 32'h1A80_0030, 16'h5A5A, 16'h0000},
    '{1'b0, 32'h1B00_0000, 16'h0000, 16'hB001},
    '{1'b0, 32'h1B80_0100, 16'h0000, 16'hC001},
    '{1'b0, 32'h1A7F_FFFE, 16'h0000, 16'hDEAD},
    '{1'b1, 32'h1B80_0102, 16'h1234, 16'h0000},
    '{1'b0, 32'h1D00_0000, 16'h0000, 16'hD301},
    '{1'b0, 32'h24FF_FFFE, 16'h0000, 16'hD302},
    '{1'b1, 32'h1C80_0000, 16'hCAFE, 16'h0000},
    '{1'b0, 32'h1C00_0000, 16'h0000, 16'hE501},
    '{1'b0, 32'h1C00_0400, 16'h0000, 16'hE502},
    '{1'b1, 32'h1D00_0200, 16'h0F0F, 16'h0000},
    '{1'b0, 32'h2500_0000, 16'h0000, 16'hBEEF},
    '{1'b0, 32'h1CFF_FFFE, 16'h0000, 16'hF401},
    '{1'b1, 32'h1CFF_FFFC, 16'h7777, 16'h0000}
  };

  // Expected window index per R1, -1 for no window (R2)
  function automatic int exp_idx(logic [31:0] a);
    if (a >= 32'h1A80_0000 && a <= 32'h1AFF_FFFF) return 0;
    if (a >= 32'h1B00_0000 && a <= 32'h1B7F_FFFF) return 1;
    if (a >= 32'h1B80_0000 && a <= 32'h1BFF_FFFF) return 2;
    if (a >= 32'h1C00_0000 && a <= 32'h1C7F_FFFF) return 5;
    if (a >= 32'h1C80_0000 && a <= 32'h1CFF_FFFF) return 4;
    if (a >= 32'h1D00_0000 && a <= 32'h24FF_FFFF) return 3;
    return -1;
  endfunction

  // Model history of the previous completed access
  bit          m_hv, m_hr;
  int          m_hidx;
  logic [21:0] m_hpage;

  // Observed counts for one access
  int o_lat, o_pre, o_cs, o_oe, o_we, o_adv, o_doe, o_idx, o_rdy, o_dbad, o_abad;
  logic o_err;
  logic [15:0] o_rd;

  task automatic access(logic wr, logic [31:0] addr, logic [15:0] wd, logic [15:0] din);
    bit seen_cs = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd; bus_din = din;
    o_lat = 0; o_pre = 0; o_cs = 0; o_oe = 0; o_we = 0; o_adv = 0; o_doe = 0;
    o_idx = -1; o_rdy = 0; o_dbad = 0; o_abad = 0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (n == 0) req_valid = 0;
      o_lat++;
      if (bus_cs_n != 6'h3F) begin
        seen_cs = 1; o_cs++;
        for (int b = 0; b < 6; b++) if (!bus_cs_n[b]) o_idx = b;
        if (bus_addr != addr[9:1]) o_abad++;
      end else if (!seen_cs && !rsp_valid) o_pre++;
      if (!bus_oe_n) o_oe++;
      if (!bus_we_n) begin
        o_we++;
        if (bus_dout != wd) o_dbad++;
      end
      if (!bus_adv_n) o_adv++;
      if (bus_doe) o_doe++;
      if (req_ready) o_rdy++;
      if (rsp_valid) begin
        o_err = rsp_err; o_rd = rsp_rdata;
        break;
      end
    end
  endtask

  task automatic run_vec(logic wr, logic [31:0] addr, logic [15:0] wd, logic [15:0] din);
    int idx, rec, dl, adv, gap, acc, hold, ao, rh;
    bit newp;
    access(wr, addr, wd, din);
    idx = exp_idx(addr);
    if (idx < 0) begin
      chk(o_err == 1'b1, "R2", "error flag", o_err, 1);
      chk(o_lat == 1, "R2", "error latency", o_lat, 1);
      chk(o_cs == 0 && o_oe == 0 && o_we == 0, "R2", "bus quiet", o_cs + o_oe + o_we, 0);
    end else begin
      rec  = (m_hv && m_hr && (m_hidx != idx || wr)) ?
             ((recov[idx*4 +: 4] == 0) ? 1 : int'(recov[idx*4 +: 4])) : 0;
      newp = !m_hv || (m_hidx != idx) || (m_hpage != addr[31:10]);
      dl   = newp ? int'(wr ? wr_delta[idx*8 +: 8] : rd_delta[idx*8 +: 8]) : 0;
      ao   = int'(adv_oe[idx*2 +: 2]);
      rh   = int'(rd_hold[idx*4 +: 4]);
      adv  = fast[idx] ? 1 : 0;
      gap  = fast[idx] ? ((wr ? ao : (ao > rh ? ao : rh)) + int'(addr_hold[idx])) : 0;
      acc  = int'(wr ? wr_wait[idx*4 +: 4] : rd_wait[idx*4 +: 4]) + 1;
      hold = wr ? int'(wr_hold[idx*4 +: 4]) + 1 : 0;
      chk(o_err == 1'b0 && o_idx == idx, "R1", "chip select index", o_idx, idx);
      chk(o_abad == 0, "R1", "word address mismatches", o_abad, 0);
      chk(o_pre == rec, "R6", "turnaround cycles", o_pre, rec);
      chk(o_adv == adv, "R8", "ADV cycles", o_adv, adv);
      chk(o_cs == dl + adv + gap + acc + hold, "R7", "CS-low cycles (delta, R9 gap)",
          o_cs, dl + adv + gap + acc + hold);
      chk(o_lat == rec + o_cs + 1 && o_rdy == 0, "R10", "response latency", o_lat,
          rec + dl + adv + gap + acc + hold + 1);
      if (wr) begin
        chk(o_we == acc && o_oe == 0, "R4", "WE-low cycles", o_we, acc);
        chk(o_dbad == 0, "R4", "write data mismatches", o_dbad, 0);
        chk(o_doe == acc + hold, "R5", "data enable cycles", o_doe, acc + hold);
      end else begin
        chk(o_oe == acc && o_we == 0 && o_doe == 0, "R3", "OE-low cycles", o_oe, acc);
        chk(o_rd == din, "R3", "read data", o_rd, din);
      end
      m_hv = 1; m_hr = !wr; m_hidx = idx; m_hpage = addr[31:10];
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after response", req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; bus_din = '0;
    for (int i = 0; i < 6; i++) begin
      rd_wait[i*4 +: 4]  = 4'(i + 1);
      wr_wait[i*4 +: 4]  = 4'(i);
      recov[i*4 +: 4]    = (i == 0) ? 4'd0 : 4'(i + 1);
      wr_hold[i*4 +: 4]  = 4'(i % 3);
      rd_delta[i*8 +: 8] = (i % 2 == 0) ? 8'(i + 2) : 8'd0;
      wr_delta[i*8 +: 8] = (i % 2 == 1) ? 8'd3 : 8'd0;
      fast[i]            = (i >= 3);
      adv_oe[i*2 +: 2]   = 2'(i % 4);
      rd_hold[i*4 +: 4]  = (i == 4) ? 4'd5 : 4'd1;
      addr_hold[i]       = (i == 5);
    end
    m_hv = 0; m_hr = 0; m_hidx = 0; m_hpage = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11", "ready/response", {req_ready, rsp_valid}, 2'b10);
    chk(bus_cs_n == 6'h3F && bus_oe_n && bus_we_n && bus_adv_n && !bus_doe, "R11",
        "bus idle", {bus_cs_n, bus_oe_n, bus_we_n, bus_adv_n, bus_doe}, 10'h3FE);

    for (int v = 0; v < NV; v++) run_vec(VECS[v].wr, VECS[v].addr, VECS[v].wd, VECS[v].din);

    // R7: maximum first-access latency on a fresh page of CS0
    rd_delta[7:0] = 8'd255;
    run_vec(1'b0, 32'h1A80_0400, 16'h0, 16'h3C3C);
    // R6: write then read on another select needs no turnaround
    run_vec(1'b1, 32'h1B00_0004, 16'hABCD, 16'h0);
    run_vec(1'b0, 32'h1B80_0004, 16'h0, 16'h4242);
    // R2: error in between must not disturb history; same-page read follows
    run_vec(1'b1, 32'h0000_0000, 16'h1111, 16'h0);
    run_vec(1'b0, 32'h1B80_0006, 16'h0, 16'h4343);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule